// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block collects every interrupt source of a multi-stream audio DMA controller and drives a single level-sensitive interrupt line. The stream DMA engines, the command/response rings and the codec link only deliver single-cycle event pulses. The aggregator records each pulse in a sticky status register. Software clears a status bit by writing 1 to it. The block combines the recorded status with per-source enable bits into one global status word and one interrupt line.

Status is always recorded, whatever its enable says. The global status word reports a source only when that source's local enables select it. The summary bit reports any pending global cause even when no enable in the global control register selects it. The interrupt line is the only output that honours the global control enables. Software reaches all registers through a small synchronous write and combinational read port.

Top module: `audio_irq_agg`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq_o` is 0.
- R2: Stream n has its status at address 16+n. Buffer completion sets bit 2, FIFO error sets bit 3 and descriptor error sets bit 4. Writing 1 to a bit clears it, writing 0 keeps it, and all other bits read 0.
- R3: When an event pulse and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R4: The response status register sits at address 4. Every response-written pulse sets bit 0, even when its enable is 0. Every response-overrun pulse sets bit 2. Both bits are cleared by writing 1.
- R5: The codec change register sits at address 2. It holds flags in bits 0 to 14, one per codec input, each set by its pulse and cleared by writing 1. Bit 15 reads 0.
- R6: Bit n of the global status (address 1, n below the stream count) is 1 when the stream n status ANDed with the stream n control (address 8+n, enables at bits 2, 3, 4) is nonzero.
- R7: Global status bit 30 is 1 when either of two conditions holds. The first is a nonzero result of response status ANDed with response control (address 3, response enable bit 0, overrun enable bit 2). The second is any codec change flag being set.
- R8: Global status bit 31 is the OR of global status bits 0 to 30, whatever the global control enables are.
- R9: `irq_o` is 1 exactly when two conditions hold: global control bit 31 is 1, and global status ANDed with global control over bit 30 and the stream bits is nonzero. The line and all registers take their new values at the clock edge that samples the event or write.
- R10: A write that clears global control bit 31 drops `irq_o` at that same edge, even while causes stay pending.
- R11: The control registers keep only their defined bits and read 0 elsewhere. Global control (address 0) keeps bits 31, 30 and the stream bits. Response control keeps bits 0 and 2. Stream control keeps bits 2 to 4.
- R12: Writes to address 1 have no effect, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register word address for read and write |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| ev_buf_done | input | NUM_STREAMS | Per-stream buffer completion pulse |
| ev_fifo_err | input | NUM_STREAMS | Per-stream FIFO error pulse |
| ev_desc_err | input | NUM_STREAMS | Per-stream descriptor error pulse |
| ev_resp_wr | input | 1 | Response written to the response ring |
| ev_resp_ovr | input | 1 | Response ring overrun |
| ev_codec_chg | input | NUM_CODECS | Per-codec state-change pulse |
| irq_o | output | 1 | Registered level-sensitive interrupt line |

## Verification
Every register, the global status and `irq_o` are loaded from next-state values. A pulse or write driven in one cycle is therefore visible at the very next clock edge, with no second register stage. Reads are combinational from the address. The bench drives each stimulus for a single edge and then removes it. After that edge it moves the address to the register under check and compares one time step later, well before the following edge. A bench model, updated at the same edge from the requirement rules, supplies the expected read value and line level for random and directed stimulus.

// File: rtl/agg_pkg.sv
// Shared constants for the audio interrupt aggregator: bit positions and the
// register address map. Assumes a 32-bit register port with word addresses.
package agg_pkg;
    localparam int GIE_BIT   = 31;
    localparam int CIE_BIT   = 30;
    localparam int RSP_INT   = 0;
    localparam int RSP_OVR   = 2;
    localparam int STR_DONE  = 2;
    localparam int STR_FIFO  = 3;
    localparam int STR_DESC  = 4;

    localparam logic [7:0] STR_MASK = 8'h1C;
    localparam logic [7:0] RSP_MASK = 8'h05;

    localparam int ADDR_W        = 5;
    localparam int A_GCTL        = 0;
    localparam int A_GSTS        = 1;
    localparam int A_CODEC       = 2;
    localparam int A_RCTL        = 3;
    localparam int A_RSTS        = 4;
    localparam int A_SCTL_BASE   = 8;
    localparam int A_SSTS_BASE   = 16;

    typedef logic [31:0] word_t;
endpackage

// File: rtl/status_w1c.sv
// Sticky status register with write-1-to-clear. Hardware set pulses win over a
// clear in the same cycle. Bits outside MASK are held at 0. Exposes the
// next-state value so that downstream logic can register from it.
module status_w1c #(
    parameter int         W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] d_o,
    output logic [W-1:0] q_o
);
    logic [W-1:0] clr_bits;

    // Next state: drop cleared bits, then apply set pulses so sets win.
    always_comb begin
        clr_bits = clr_we_i ? clr_data_i : '0;
        d_o      = ((q_o & ~clr_bits) | set_i) & MASK;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_o;
    end
endmodule

// File: rtl/irq_eval.sv
// Combinational evaluation of the global status word and the interrupt level
// from a full set of status and enable values. Assumes NS <= 30.
module irq_eval
    import agg_pkg::*;
#(
    parameter int NS = 8,
    parameter int CW = 16
) (
    input  word_t                gctl_i,
    input  logic [NS-1:0][7:0]   ssts_i,
    input  logic [NS-1:0][7:0]   sctl_i,
    input  logic [7:0]           rsts_i,
    input  logic [7:0]           rctl_i,
    input  logic [CW-1:0]        codec_i,
    output word_t                gsts_o,
    output logic                 irq_o
);
    localparam word_t LINE_MASK = (word_t'(1) << CIE_BIT) | ((word_t'(1) << NS) - word_t'(1));

    logic [NS-1:0] strm_hit;

    // One cause bit per stream: status selected by its own enables.
    for (genvar n = 0; n < NS; n++) begin : g_strm
        assign strm_hit[n] = |(ssts_i[n] & sctl_i[n] & STR_MASK);
    end

    // Assemble the global status word and the gated line level.
    always_comb begin
        gsts_o          = '0;
        gsts_o[NS-1:0]  = strm_hit;
        gsts_o[CIE_BIT] = (|(rsts_i & rctl_i & RSP_MASK)) | (|codec_i);
        gsts_o[GIE_BIT] = |gsts_o[30:0];
        irq_o           = gctl_i[GIE_BIT] & (|(gsts_o & gctl_i & LINE_MASK));
    end
endmodule

// File: rtl/audio_irq_agg.sv
// Audio controller interrupt aggregator. Holds the global, response-ring,
// codec and per-stream status/control registers, and drives a registered
// interrupt line. Status and the line are both loaded from next-state values,
// so any event or write is reflected at the edge that samples it.
// Assumes NUM_STREAMS <= 8 and NUM_CODECS <= 15.
module audio_irq_agg
    import agg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_we,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [NUM_STREAMS-1:0] ev_buf_done,
    input  logic [NUM_STREAMS-1:0] ev_fifo_err,
    input  logic [NUM_STREAMS-1:0] ev_desc_err,
    input  logic                   ev_resp_wr,
    input  logic                   ev_resp_ovr,
    input  logic [NUM_CODECS-1:0]  ev_codec_chg,
    output logic                   irq_o
);
    localparam int    NS         = NUM_STREAMS;
    localparam int    CW         = 16;
    localparam word_t GCTL_MASK  = (word_t'(3) << CIE_BIT) | ((word_t'(1) << NS) - word_t'(1));
    localparam logic [CW-1:0] CODEC_MASK = CW'((32'h1 << NUM_CODECS) - 32'h1);

    word_t                gctl_q, gctl_d, gsts_q, gsts_d;
    logic [7:0]           rctl_q, rctl_d;
    logic [NS-1:0][7:0]   sctl_q, sctl_d;
    logic [NS-1:0][7:0]   ssts_q, ssts_d;
    logic [7:0]           rsts_q, rsts_d;
    logic [CW-1:0]        codec_q, codec_d;
    logic                 irq_d;

    logic wr_gctl, wr_rctl, wr_rsts, wr_codec;
    assign wr_gctl  = reg_we && (reg_addr == ADDR_W'(A_GCTL));
    assign wr_rctl  = reg_we && (reg_addr == ADDR_W'(A_RCTL));
    assign wr_rsts  = reg_we && (reg_addr == ADDR_W'(A_RSTS));
    assign wr_codec = reg_we && (reg_addr == ADDR_W'(A_CODEC));

    // Next-state of the global and response-ring control registers.
    always_comb begin
        gctl_d = wr_gctl ? (reg_wdata & GCTL_MASK) : gctl_q;
        rctl_d = wr_rctl ? (reg_wdata[7:0] & RSP_MASK) : rctl_q;
    end

    // Response-ring status: response and overrun pulses.
    status_w1c #(.W(8), .MASK(RSP_MASK)) u_rsts (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      ({5'b0, ev_resp_ovr, 1'b0, ev_resp_wr}),
        .clr_we_i   (wr_rsts),
        .clr_data_i (reg_wdata[7:0]),
        .d_o        (rsts_d),
        .q_o        (rsts_q)
    );

    // Codec state-change flags, one per codec input.
    status_w1c #(.W(CW), .MASK(CODEC_MASK)) u_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (CW'(ev_codec_chg)),
        .clr_we_i   (wr_codec),
        .clr_data_i (reg_wdata[CW-1:0]),
        .d_o        (codec_d),
        .q_o        (codec_q)
    );

    // Per-stream control and status registers.
    for (genvar n = 0; n < NS; n++) begin : g_stream
        logic wr_ctl, wr_sts;
        assign wr_ctl = reg_we && (reg_addr == ADDR_W'(A_SCTL_BASE + n));
        assign wr_sts = reg_we && (reg_addr == ADDR_W'(A_SSTS_BASE + n));
        assign sctl_d[n] = wr_ctl ? (reg_wdata[7:0] & STR_MASK) : sctl_q[n];

        status_w1c #(.W(8), .MASK(STR_MASK)) u_ssts (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      ({3'b0, ev_desc_err[n], ev_fifo_err[n], ev_buf_done[n], 2'b0}),
            .clr_we_i   (wr_sts),
            .clr_data_i (reg_wdata[7:0]),
            .d_o        (ssts_d[n]),
            .q_o        (ssts_q[n])
        );
    end

    // Global status and line level from next-state values.
    irq_eval #(.NS(NS), .CW(CW)) u_eval (
        .gctl_i  (gctl_d),
        .ssts_i  (ssts_d),
        .sctl_i  (sctl_d),
        .rsts_i  (rsts_d),
        .rctl_i  (rctl_d),
        .codec_i (codec_d),
        .gsts_o  (gsts_d),
        .irq_o   (irq_d)
    );

    // Control, global status and line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= '0;
            rctl_q <= '0;
            sctl_q <= '0;
            gsts_q <= '0;
            irq_o  <= 1'b0;
        end else begin
            gctl_q <= gctl_d;
            rctl_q <= rctl_d;
            sctl_q <= sctl_d;
            gsts_q <= gsts_d;
            irq_o  <= irq_d;
        end
    end

    // Read multiplexer; unmapped addresses return 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_GCTL):  reg_rdata = gctl_q;
            ADDR_W'(A_GSTS):  reg_rdata = gsts_q;
            ADDR_W'(A_CODEC): reg_rdata = 32'(codec_q);
            ADDR_W'(A_RCTL):  reg_rdata = 32'(rctl_q);
            ADDR_W'(A_RSTS):  reg_rdata = 32'(rsts_q);
            default: begin
                for (int n = 0; n < NS; n++) begin
                    if (reg_addr == ADDR_W'(A_SCTL_BASE + n)) reg_rdata = 32'(sctl_q[n]);
                    if (reg_addr == ADDR_W'(A_SSTS_BASE + n)) reg_rdata = 32'(ssts_q[n]);
                end
            end
        endcase
    end
endmodule

// File: rtl/agg_chk.sv
// Assertion checker for audio_irq_agg, attached by bind. Observes the
// registered state and the event inputs; all properties are reset-qualified.
module agg_chk #(
    parameter int NS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [31:0] gctl,
    input logic [31:0] gsts,
    input logic [7:0]  rsts,
    input logic [15:0] codec,
    input logic [7:0]  ssts0,
    input logic        ev_resp_wr,
    input logic        ev_resp_ovr,
    input logic        ev_buf0,
    input logic        reg_we
);
    // R10
    line_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gctl[31] |-> !irq);

    // R4
    resp_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_resp_wr |=> rsts[0]);

    // R3
    strm_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf0 |=> ssts0[2]);

    // R8
    summary_codec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|codec) |-> gsts[31]);

    // R4
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !ev_resp_wr && !ev_resp_ovr) |=> $stable(rsts));

    // R9
    line_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gsts[31]);
endmodule

bind audio_irq_agg agg_chk #(.NS(NUM_STREAMS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq_o),
    .gctl        (gctl_q),
    .gsts        (gsts_q),
    .rsts        (rsts_q),
    .codec       (codec_q),
    .ssts0       (ssts_q[0]),
    .ev_resp_wr  (ev_resp_wr),
    .ev_resp_ovr (ev_resp_ovr),
    .ev_buf0     (ev_buf_done[0]),
    .reg_we      (reg_we)
);

// File: tb/tb_audio_irq_agg.sv
`timescale 1ns/1ps
module tb_audio_irq_agg;
    localparam int NS = 8;
    localparam int NC = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NS-1:0] ev_buf_done = '0, ev_fifo_err = '0, ev_desc_err = '0;
    logic        ev_resp_wr = 1'b0, ev_resp_ovr = 1'b0;
    logic [NC-1:0] ev_codec_chg = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    audio_irq_agg #(.NUM_STREAMS(NS), .NUM_CODECS(NC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_buf_done(ev_buf_done), .ev_fifo_err(ev_fifo_err), .ev_desc_err(ev_desc_err),
        .ev_resp_wr(ev_resp_wr), .ev_resp_ovr(ev_resp_ovr),
        .ev_codec_chg(ev_codec_chg), .irq_o(irq_o)
    );

    // Bench model of the register state, built from the requirements.
    logic [31:0] m_gctl;
    logic [7:0]  m_rctl, m_rsts;
    logic [15:0] m_codec;
    logic [7:0]  m_sctl [NS];
    logic [7:0]  m_ssts [NS];

    function automatic logic [31:0] exp_gsts();
        logic [31:0] g = '0;
        for (int n = 0; n < NS; n++) g[n] = |(m_ssts[n] & m_sctl[n] & 8'h1C);
        g[30] = (|(m_rsts & m_rctl & 8'h05)) | (|m_codec);
        g[31] = |g[30:0];
        return g;
    endfunction

    function automatic logic exp_irq();
        logic [31:0] g = exp_gsts();
        return m_gctl[31] & (|(g & m_gctl & 32'h400000FF));
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a == 0) return m_gctl;
        if (a == 1) return exp_gsts();
        if (a == 2) return 32'(m_codec);
        if (a == 3) return 32'(m_rctl);
        if (a == 4) return 32'(m_rsts);
        if (a >= 8 && a < 8 + NS) return 32'(m_sctl[a - 8]);
        if (a >= 16 && a < 16 + NS) return 32'(m_ssts[a - 16]);
        return 32'h0;
    endfunction

    function automatic string tag_for(input logic [4:0] a);
        if (a == 0 || a == 3 || (a >= 8 && a < 8 + NS)) return "R11";
        if (a == 1) return "R6/R7/R8";
        if (a == 2) return "R5";
        if (a == 4) return "R4";
        if (a >= 16 && a < 16 + NS) return "R2";
        return "R12";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_gctl = '0; m_rctl = '0; m_rsts = '0; m_codec = '0;
        for (int n = 0; n < NS; n++) begin m_sctl[n] = '0; m_ssts[n] = '0; end
    endtask

    // Apply one cycle of stimulus, update the model at that edge, then check
    // the read of address ra and the line before the next edge.
    task automatic step(input logic [4:0] a, input logic we, input logic [31:0] d,
                        input logic [NS-1:0] bd, input logic [NS-1:0] fe,
                        input logic [NS-1:0] de, input logic rw, input logic ro,
                        input logic [NC-1:0] cc, input logic [4:0] ra);
        reg_addr = a; reg_we = we; reg_wdata = d;
        ev_buf_done = bd; ev_fifo_err = fe; ev_desc_err = de;
        ev_resp_wr = rw; ev_resp_ovr = ro; ev_codec_chg = cc;
        @(posedge clk);
        #1;
        for (int n = 0; n < NS; n++) begin
            logic [7:0] clr = (we && a == 5'(16 + n)) ? d[7:0] : 8'h0;
            m_ssts[n] = ((m_ssts[n] & ~clr) | {3'b0, de[n], fe[n], bd[n], 2'b0}) & 8'h1C;
            if (we && a == 5'(8 + n)) m_sctl[n] = d[7:0] & 8'h1C;
        end
        m_rsts  = ((m_rsts & ~((we && a == 4) ? d[7:0] : 8'h0)) | {5'b0, ro, 1'b0, rw}) & 8'h05;
        m_codec = ((m_codec & ~((we && a == 2) ? d[15:0] : 16'h0)) | 16'(cc)) & 16'h7FFF;
        if (we && a == 0) m_gctl = d & 32'hC00000FF;
        if (we && a == 3) m_rctl = d[7:0] & 8'h05;
        reg_we = 1'b0; ev_buf_done = '0; ev_fifo_err = '0; ev_desc_err = '0;
        ev_resp_wr = 1'b0; ev_resp_ovr = 1'b0; ev_codec_chg = '0;
        reg_addr = ra;
        #1;
        chk(tag_for(ra), reg_rdata, exp_read(ra));
        chk("R9", 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [4:0] ra);
        step(a, 1'b1, d, '0, '0, '0, 1'b0, 1'b0, '0, ra);
    endtask

    task automatic idle(input logic [4:0] ra);
        step(5'd0, 1'b0, 32'h0, '0, '0, '0, 1'b0, 1'b0, '0, ra);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R1: every register and the line are zero after reset
        for (int a = 0; a < 32; a++) begin
            reg_addr = 5'(a);
            #0.1;
            chk("R1", reg_rdata, 32'h0);
        end
        chk("R1", 32'(irq_o), 32'h0);

        // R11: control registers keep only defined bits
        wr(5'd0, 32'hFFFFFFFF, 5'd0);
        chk("R11", reg_rdata, 32'hC00000FF);
        wr(5'd3, 32'hFFFFFFFF, 5'd3);
        chk("R11", reg_rdata, 32'h00000005);
        wr(5'd10, 32'hFFFFFFFF, 5'd10);
        chk("R11", reg_rdata, 32'h0000001C);

        // R2: buffer completion on stream 2, then write 0 keeps and 1 clears
        step(5'd0, 1'b0, 0, 8'h04, '0, '0, 1'b0, 1'b0, '0, 5'd18);
        chk("R2", reg_rdata, 32'h00000004);
        chk("R9", 32'(irq_o), 32'h1);
        wr(5'd18, 32'h0, 5'd18);
        chk("R2", reg_rdata, 32'h00000004);
        wr(5'd18, 32'h4, 5'd18);
        chk("R2", reg_rdata, 32'h0);
        chk("R9", 32'(irq_o), 32'h0);

        // R3: FIFO error on stream 1 with a clear of the same bit
        step(5'd17, 1'b1, 32'h08, '0, 8'h02, '0, 1'b0, 1'b0, '0, 5'd17);
        chk("R3", reg_rdata, 32'h00000008);
        wr(5'd17, 32'hFF, 5'd17);

        // R4: response flag set with its enable off; overrun at bit 2
        wr(5'd3, 32'h0, 5'd4);
        step(5'd0, 1'b0, 0, '0, '0, '0, 1'b1, 1'b0, '0, 5'd4);
        chk("R4", reg_rdata, 32'h00000001);
        chk("R9", 32'(irq_o), 32'h0);
        step(5'd0, 1'b0, 0, '0, '0, '0, 1'b0, 1'b1, '0, 5'd1);
        chk("R7", reg_rdata, 32'h0);
        wr(5'd3, 32'h4, 5'd1);
        chk("R7", reg_rdata, 32'hC0000000);
        wr(5'd4, 32'h5, 5'd4);
        chk("R4", reg_rdata, 32'h0);

        // R8: codec flag with every global enable off still sets summary
        wr(5'd0, 32'h0, 5'd1);
        step(5'd0, 1'b0, 0, '0, '0, '0, 1'b0, 1'b0, 15'h4001, 5'd1);
        chk("R8", reg_rdata, 32'hC0000000);
        chk("R8", 32'(irq_o), 32'h0);
        idle(5'd2);
        chk("R5", reg_rdata, 32'h00004001);
        wr(5'd2, 32'hFFFF_0001, 5'd2);
        chk("R5", reg_rdata, 32'h00004000);

        // R10: line up with cause pending, then drop the global enable
        wr(5'd0, 32'hC0000000, 5'd0);
        chk("R9", 32'(irq_o), 32'h1);
        wr(5'd0, 32'h40000000, 5'd1);
        chk("R10", 32'(irq_o), 32'h0);
        chk("R10", reg_rdata, 32'hC0000000);

        // R12: write to global status ignored; unmapped read is zero
        wr(5'd1, 32'h0, 5'd1);
        chk("R12", reg_rdata, 32'hC0000000);
        wr(5'd31, 32'hFFFFFFFF, 5'd31);
        chk("R12", reg_rdata, 32'h0);
        wr(5'd2, 32'hFFFF, 5'd2);

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] a, ra;
            logic we;
            logic [31:0] d;
            a  = 5'($urandom_range(0, 31));
            ra = 5'($urandom_range(0, 31));
            we = ($urandom_range(0, 2) == 0);
            d  = $urandom();
            step(a, we, d,
                 ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'h0,
                 ($urandom_range(0, 9) == 0) ? 8'($urandom()) : 8'h0,
                 ($urandom_range(0, 9) == 0) ? 8'($urandom()) : 8'h0,
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 11) == 0) ? 15'($urandom()) : 15'h0, ra);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule